// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives a debug memory-access controller to place one word into a target's on-chip flash, or to run one flash erase. A command is accepted with a single-cycle `start`. The block then issues a fixed, ordered chain of requests: halt the core, write the three flash control registers, write the data word (or a dummy word for an erase), and switch the bus back to read mode. It then clocks out a counted burst of `tclk` pulses that times the flash operation, and finally writes control register 1 again to relock the flash.

Each request is presented on `reqValid`/`reqOp`/`reqAddr`/`reqData` and held until the access controller answers with a one-cycle `memDone`. A program command always uses a fixed pulse count set by a parameter. An erase command uses the caller's 16-bit `pulseCount` and the caller's erase mode code. Usual mode codes are 0xA502 for one segment, 0xA504 for main-only, 0xA506 for a mass erase, 0xA50C for all main memory and 0xA50E for everything. A full-chip mass erase is normally run at address 0xFFFE with 0x3000 pulses.

Top module: `flash_seq_top`

## Requirements
- R1: After reset the block is idle: `reqValid`, `busy` and `done` are low and `tclk` is high.
- R2: A program command (`cmdErase`=0) issues, in this order: halt (`reqOp`=0), word write (`reqOp`=1) 0xA540 to 0x0128, write 0xA540 to 0x012A, write 0xA500 to 0x012C, write `targetData` to `targetAddr`, control request (`reqOp`=2, `reqAddr`=0) with data 0x2409, the pulse burst, then write 0xA500 to 0x0128.
- R3: An erase command (`cmdErase`=1) follows the same chain, except that it writes `eraseMode` to 0x0128 first and writes the dummy word 0x55AA to `targetAddr` in place of the data.
- R4: Each request stays asserted with stable op, address and data until `memDone` is seen. Exactly one step is taken per `memDone`. A `memDone` while no request is pending has no effect.
- R5: Each pulse holds `tclk` low for `HALF_PERIOD` cycles and then high for `HALF_PERIOD` cycles. `tclk` is high at every other time, and no request is raised during the burst.
- R6: A program burst has `PROG_PULSES` pulses. An erase burst has `pulseCount` pulses. A count of zero skips straight to the relock write.
- R7: `busy` rises the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle after the relock write is acknowledged, and `busy` falls in that same cycle.
- R8: The command inputs are captured when `start` is accepted. A `start` or an input change while `busy` has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmdErase | input | 1 | 0 = program a word, 1 = erase |
| eraseMode | input | DATA_W | Mode code written first to control register 1 for an erase |
| targetAddr | input | ADDR_W | Word address to program, or address of the erase dummy write |
| targetData | input | DATA_W | Word to program |
| pulseCount | input | CNT_W | Pulse count for an erase |
| memDone | input | 1 | One-cycle completion strobe from the access controller |
| reqValid | output | 1 | Memory-access request pending |
| reqOp | output | 2 | 0 halt, 1 word write, 2 bus control value |
| reqAddr | output | ADDR_W | Request address |
| reqData | output | DATA_W | Request data / control value |
| tclk | output | 1 | Flash timing clock, idle high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `HALF_PERIOD`=2 and `PROG_PULSES`=6. The short program burst lets many program runs fit in the run, while a two-cycle half period still exposes off-by-one errors in the low and high phase lengths. With these values, a full 0x3000-pulse mass erase at 0xFFFE also fits, along with a zero-count erase and short segment erases. The bench varies the responder latency from zero to three cycles and injects stray `memDone` strobes both while idle and during a burst.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    OP_HALT  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CTRL  = 2'd2
  } memOp_e;

  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] STEP_HALT     = 3'd0;
  localparam logic [STEP_W-1:0] STEP_UNLOCK   = 3'd1;
  localparam logic [STEP_W-1:0] STEP_CLKSEL   = 3'd2;
  localparam logic [STEP_W-1:0] STEP_SEGPROT  = 3'd3;
  localparam logic [STEP_W-1:0] STEP_PAYLOAD  = 3'd4;
  localparam logic [STEP_W-1:0] STEP_READMODE = 3'd5;
  localparam logic [STEP_W-1:0] STEP_PULSE    = 3'd6;
  localparam logic [STEP_W-1:0] STEP_RELOCK   = 3'd7;

  localparam logic [15:0] FCTL_A1     = 16'h0128;
  localparam logic [15:0] FCTL_A2     = 16'h012A;
  localparam logic [15:0] FCTL_A3     = 16'h012C;
  localparam logic [15:0] VAL_WRITE   = 16'hA540;
  localparam logic [15:0] VAL_CLKSEL  = 16'hA540;
  localparam logic [15:0] VAL_LOCK    = 16'hA500;
  localparam logic [15:0] VAL_DUMMY   = 16'h55AA;
  localparam logic [15:0] VAL_RDMODE  = 16'h2409;

  typedef struct packed {
    logic              load;
    logic              pulseLoad;
    logic              pulseRun;
    logic [STEP_W-1:0] step;
  } seqStrobe_t;

endpackage

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memDone,
  input  logic       pulsesDone,
  output seqStrobe_t strobe,
  output logic       reqValid,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_PULSE} state_e;

  state_e            state;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= STEP_HALT;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_MEM;
            step  <= STEP_HALT;
          end
        end
        S_MEM: begin
          if (memDone) begin
            if (step == STEP_READMODE) begin
              state <= S_PULSE;
              step  <= STEP_PULSE;
            end else if (step == STEP_RELOCK) begin
              state <= S_IDLE;
              step  <= STEP_HALT;
              done  <= 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        S_PULSE: begin
          if (pulsesDone) begin
            state <= S_MEM;
            step  <= STEP_RELOCK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load      = (state == S_IDLE) && start;
    strobe.pulseLoad = (state == S_MEM) && memDone && (step == STEP_READMODE);
    strobe.pulseRun  = (state == S_PULSE);
    strobe.step      = step;
    reqValid         = (state == S_MEM);
    busy             = (state != S_IDLE);
  end

endmodule

// File: rtl/fsq_datapath.sv
module fsq_datapath
  import fsq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int HALF_PERIOD = 2,
  parameter int PROG_PULSES = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmdErase,
  input  logic [DATA_W-1:0] eraseMode,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] targetData,
  input  logic [CNT_W-1:0]  pulseCount,
  output logic              pulsesDone,
  output logic [1:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              tclk
);

  localparam int PH_W    = $clog2(2 * HALF_PERIOD + 1);
  localparam int PH_LAST = 2 * HALF_PERIOD - 1;

  logic              isErase;
  logic [DATA_W-1:0] modeReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [CNT_W-1:0]  countReg;
  logic [CNT_W-1:0]  remain;
  logic [PH_W-1:0]   phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isErase  <= 1'b0;
      modeReg  <= '0;
      addrReg  <= '0;
      dataReg  <= '0;
      countReg <= '0;
    end else if (strobe.load) begin
      isErase  <= cmdErase;
      modeReg  <= eraseMode;
      addrReg  <= targetAddr;
      dataReg  <= targetData;
      countReg <= pulseCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      phase  <= '0;
    end else if (strobe.pulseLoad) begin
      remain <= isErase ? countReg : CNT_W'(PROG_PULSES);
      phase  <= '0;
    end else if (strobe.pulseRun && remain != '0) begin
      if (phase == PH_W'(PH_LAST)) begin
        phase  <= '0;
        remain <= remain - 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign pulsesDone = (remain == '0);
  assign tclk = !(strobe.pulseRun && remain != '0 && phase < PH_W'(HALF_PERIOD));

  always_comb begin
    reqOp   = OP_HALT;
    reqAddr = '0;
    reqData = '0;
    unique case (strobe.step)
      STEP_UNLOCK: begin
        reqOp   = OP_WRITE;
        reqAddr = ADDR_W'(FCTL_A1);
        reqData = isErase ? modeReg : DATA_W'(VAL_WRITE);
      end
      STEP_CLKSEL: begin
        reqOp   = OP_WRITE;
        reqAddr = ADDR_W'(FCTL_A2);
        reqData = DATA_W'(VAL_CLKSEL);
      end
      STEP_SEGPROT: begin
        reqOp   = OP_WRITE;
        reqAddr = ADDR_W'(FCTL_A3);
        reqData = DATA_W'(VAL_LOCK);
      end
      STEP_PAYLOAD: begin
        reqOp   = OP_WRITE;
        reqAddr = addrReg;
        reqData = isErase ? DATA_W'(VAL_DUMMY) : dataReg;
      end
      STEP_READMODE: begin
        reqOp   = OP_CTRL;
        reqData = DATA_W'(VAL_RDMODE);
      end
      STEP_RELOCK: begin
        reqOp   = OP_WRITE;
        reqAddr = ADDR_W'(FCTL_A1);
        reqData = DATA_W'(VAL_LOCK);
      end
      default: begin
        reqOp = OP_HALT;
      end
    endcase
  end

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import fsq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int HALF_PERIOD = 2,
  parameter int PROG_PULSES = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cmdErase,
  input  logic [DATA_W-1:0] eraseMode,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] targetData,
  input  logic [CNT_W-1:0]  pulseCount,
  input  logic              memDone,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              tclk,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strobe;
  logic       pulsesDone;

  fsq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memDone    (memDone),
    .pulsesDone (pulsesDone),
    .strobe     (strobe),
    .reqValid   (reqValid),
    .busy       (busy),
    .done       (done)
  );

  fsq_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .HALF_PERIOD (HALF_PERIOD),
    .PROG_PULSES (PROG_PULSES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdErase   (cmdErase),
    .eraseMode  (eraseMode),
    .targetAddr (targetAddr),
    .targetData (targetData),
    .pulseCount (pulseCount),
    .pulsesDone (pulsesDone),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .tclk       (tclk)
  );

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memDone,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic              tclk,
  input logic              busy,
  input logic              done
);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memDone) |=> (reqValid && $stable(reqOp) && $stable(reqAddr) && $stable(reqData)));

  p_tclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> tclk);

  p_no_req_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tclk |-> !reqValid);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !reqValid));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_first_halt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (reqValid && reqOp == 2'd0));

endmodule

bind flash_seq_top fsq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/flash_seq_top_tb_top.sv
module flash_seq_top_tb_top;

  localparam int HALF = 2;
  localparam int PROGN = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        cmdErase = 1'b0;
  logic [15:0] eraseMode = '0;
  logic [15:0] targetAddr = '0;
  logic [15:0] targetData = '0;
  logic [15:0] pulseCount = '0;
  logic        memDone = 1'b0;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic [15:0] reqAddr;
  logic [15:0] reqData;
  logic        tclk;
  logic        busy;
  logic        done;

  always #2 clk = ~clk;

  flash_seq_top #(
    .ADDR_W(16), .DATA_W(16), .CNT_W(16), .HALF_PERIOD(HALF), .PROG_PULSES(PROGN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdErase(cmdErase),
    .eraseMode(eraseMode), .targetAddr(targetAddr), .targetData(targetData),
    .pulseCount(pulseCount), .memDone(memDone), .reqValid(reqValid),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .tclk(tclk),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // ---------------- behavioural reference model ----------------
  int          mState = 0;   // 0 idle, 1 memory step, 2 pulse burst
  int          mIdx = 0;
  int          mRem = 0;
  int          mPh = 0;
  bit          mDone = 0;
  bit          mErase = 0;
  logic [15:0] mMode, mAddr, mData;
  int          mCnt = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mIdx = 0; mRem = 0; mPh = 0; mDone = 0;
    end else begin
      mDone = 0;
      case (mState)
        0: if (start) begin
             mErase = cmdErase; mMode = eraseMode; mAddr = targetAddr;
             mData = targetData; mCnt = pulseCount;
             mState = 1; mIdx = 0;
           end
        1: if (memDone) begin
             if (mIdx == 5) begin
               mState = 2; mIdx = 6; mRem = mErase ? mCnt : PROGN; mPh = 0;
             end else if (mIdx == 7) begin
               mState = 0; mIdx = 0; mDone = 1;
             end else mIdx++;
           end
        default: if (mRem == 0) begin
             mState = 1; mIdx = 7;
           end else begin
             mPh++;
             if (mPh == 2 * HALF) begin mPh = 0; mRem--; end
           end
      endcase
    end
  end

  function automatic void expReq(output logic [1:0] op, output logic [15:0] a, output logic [15:0] d);
    op = 2'd1;
    case (mIdx)
      1: begin a = 16'h0128; d = mErase ? mMode : 16'hA540; end
      2: begin a = 16'h012A; d = 16'hA540; end
      3: begin a = 16'h012C; d = 16'hA500; end
      4: begin a = mAddr; d = mErase ? 16'h55AA : mData; end
      5: begin op = 2'd2; a = 16'h0000; d = 16'h2409; end
      7: begin a = 16'h0128; d = 16'hA500; end
      default: begin op = 2'd0; a = 16'h0000; d = 16'h0000; end
    endcase
  endfunction

  int fallCount = 0;
  logic prevTclk = 1'b1;

  always @(negedge clk) begin
    logic [1:0]  eOp;
    logic [15:0] eA, eD;
    bit          eValid, eTclk, eBusy;
    if (rstN) begin
      eValid = (mState == 1);
      eBusy  = (mState != 0);
      eTclk  = !(mState == 2 && mRem != 0 && mPh < HALF);
      expReq(eOp, eA, eD);
      checks++;
      if (reqValid !== eValid) begin errors++;
        $display("FAIL R4 reqValid act=%0b exp=%0b t=%0t", reqValid, eValid, $time); end
      if (eValid && reqOp !== eOp) begin errors++;
        $display("FAIL R2/R3 reqOp act=%0d exp=%0d step=%0d", reqOp, eOp, mIdx); end
      if (eValid && reqAddr !== eA) begin errors++;
        $display("FAIL R2/R3 reqAddr act=%h exp=%h step=%0d", reqAddr, eA, mIdx); end
      if (eValid && reqData !== eD) begin errors++;
        $display("FAIL R3 reqData act=%h exp=%h step=%0d", reqData, eD, mIdx); end
      if (tclk !== eTclk) begin errors++;
        $display("FAIL R5 tclk act=%0b exp=%0b t=%0t", tclk, eTclk, $time); end
      if (busy !== eBusy) begin errors++;
        $display("FAIL R7 busy act=%0b exp=%0b t=%0t", busy, eBusy, $time); end
      if (done !== mDone) begin errors++;
        $display("FAIL R7 done act=%0b exp=%0b t=%0t", done, mDone, $time); end
      if (prevTclk && !tclk) fallCount++;
      prevTclk = tclk;
    end
  end

  // ---------------- access-controller responder ----------------
  int  latency = 0;
  int  waitCnt = 0;
  bit  injectStray = 0;

  always @(negedge clk) begin
    if (injectStray) begin
      memDone = 1'b1; injectStray = 0; waitCnt = 0;
    end else if (memDone) begin
      memDone = 1'b0; waitCnt = 0;
    end else if (reqValid) begin
      if (waitCnt >= latency) memDone = 1'b1;
      else waitCnt++;
    end
  end

  task automatic runCmd(input bit er, input logic [15:0] mode, input logic [15:0] a,
                        input logic [15:0] d, input logic [15:0] cnt, input int lat,
                        input bit disturb, input bit strayMid, input int expPulses);
    int guard;
    latency = lat;
    @(negedge clk);
    cmdErase = er; eraseMode = mode; targetAddr = a; targetData = d; pulseCount = cnt;
    start = 1'b1;
    fallCount = 0;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R8: changed inputs and a second start while busy must not alter the run
      repeat (3) @(negedge clk);
      cmdErase = ~er; eraseMode = 16'h1234; targetAddr = 16'h4444;
      targetData = 16'h9999; pulseCount = 16'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 60000) begin
      if (strayMid && !tclk && !reqValid) begin injectStray = 1; strayMid = 0; end
      @(negedge clk); guard++;
    end
    checks++;
    if (!done) begin errors++;
      $display("FAIL R7 no done act=0 exp=1"); end
    checks++;
    if (fallCount != expPulses) begin errors++;
      $display("FAIL R6 pulse count act=%0d exp=%0d", fallCount, expPulses); end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (reqValid !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || tclk !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset act=%b%b%b%b exp=0001", reqValid, busy, done, tclk);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCmd(0, 16'h0000, 16'h1000, 16'hBEEF, 16'd0, 0, 0, 0, PROGN);   // R2 program, no wait
    runCmd(0, 16'h0000, 16'h2002, 16'hC0DE, 16'd9, 3, 1, 0, PROGN);   // R2 R8 latency + disturb
    runCmd(1, 16'hA502, 16'hE000, 16'h0000, 16'd4, 1, 0, 0, 4);       // R3 segment erase
    runCmd(1, 16'hA504, 16'hE200, 16'h0000, 16'd0, 2, 0, 0, 0);       // R6 zero pulses

    // R4: stray strobe while idle must not start anything
    repeat (2) @(negedge clk);
    injectStray = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || reqValid !== 1'b0) begin errors++;
      $display("FAIL R4 stray idle act=%b%b exp=00", busy, reqValid); end

    runCmd(1, 16'hA50E, 16'hF000, 16'h0000, 16'd2, 2, 0, 1, 2);       // R4 R5 stray in burst
    runCmd(1, 16'hA50C, 16'hC000, 16'h0000, 16'd3, 0, 1, 0, 3);       // R8 erase disturbed
    runCmd(1, 16'hA506, 16'hFFFE, 16'h0000, 16'h3000, 1, 0, 0, 16'h3000); // R6 mass erase
    runCmd(0, 16'h0000, 16'h00F0, 16'h0102, 16'd0, 1, 0, 0, PROGN);   // R2 low address

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++;
    $display("FAIL watchdog act=%0d exp<190000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule